// File: doc/BRIEF.md
# Queued Serial Frame Buffer Controller

This block is a frame queue placed in front of a simple asynchronous serial port. Software reaches it through a small synchronous register bus. When queueing is off, the port moves frames one at a time through a single data register. Each direction can also be switched to a sixteen-entry queue. In that mode software fills a run of transmit entries and starts the run, and received frames land in a ring of receive entries.

The receive ring is split into a lower half (entries 0 to 7) and an upper half (entries 8 to 15). Each half has its own full flag and its own interrupt enable, so software can empty one half while the other half fills. Flags are cleared by reading the status word and then writing 0 to the flag. A loopback mode routes the transmit line into the receiver and holds the outgoing line idle. A bit-per-clock shifter pair stands in for baud and framing logic: each frame is a low start bit, eight data bits sent LSB first, and a high stop bit.

Top module: `qsfb_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, the status word (address 1) reads 0x0020, `txd` is 1 and `irq` is 0.
- R2: Transmit path without the queue. Set control bit 13 (transmitter on) and leave bit 8 (transmit queue) clear. A write to address 2 then sends its low byte on `txd` as one low start bit, eight data bits LSB first and one high stop bit. Status bit 5 reads 1 whenever the data register is free.
- R3: Receive path without the queue. Set control bit 14 (receiver on) and leave bit 9 (receive queue) clear. A frame received on `rxd` sets status bit 4. A read of address 2 returns the frame byte and clears bit 4.
- R4: The transmit pointer reads back in control bits 7:4. A control write changes it only while `test_mode` is 1, and then it takes the written field. A start request (control bit 15) made while `test_mode` is 0 resets it to 0.
- R5: Set control bits 8 and 13 and start a run. Transmit queue entries (written at addresses 16+i) are sent in order from the pointer up to the last-entry index in control bits 3:0. The run then stops, and status bit 3 (run complete) is set.
- R6: Set control bits 9 and 14. Received frames are stored in consecutive receive entries, which are read at addresses 32+i. The write position wraps from entry 15 back to entry 0.
- R7: Status bit 0 is set when receive entries 0 to 7 have all been filled. Status bit 1 is set when entries 8 to 15 have all been filled. A bit stays set until software clears it.
- R8: `irq` is 1 exactly when (status bit 0 and control bit 10) or (status bit 1 and control bit 11) hold. Clearing an enable bit lowers `irq` but leaves the flag set.
- R9: A status write with 0 in bit 0, 1, 2 or 3 clears that flag only if the flag read as 1 in the most recent status read since the last status write. Otherwise the write has no effect.
- R10: A received frame that falls in a half whose full flag is set is discarded. It does not move the write position, and it sets the sticky overrun flag in status bit 2.
- R11: With control bits 12 (loop), 13 and 14 all set, `txd` stays 1. Transmitted frames arrive at the receiver as if they had come in on `rxd`.
- R12: If control bit 12 is set but bit 13 or bit 14 is clear, loop mode has no effect. Frames still leave on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Allows control writes to load the transmit pointer |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Receive half-full interrupt |

## Verification
The assertions rely on the bus not changing the control word while a transmit run is in progress. They also rely on the shifter never being asked to load while a frame is still going out. The bench writes control only between runs, after the last frame has been seen on the line. It drives `rxd` one bit per clock with idle gaps between frames. It also assumes that `test_mode` changes only outside bus accesses, which the bench respects by toggling it between register tasks.

// File: rtl/qsfb_pkg.sv
package qsfb_pkg;
  localparam int DW  = 8;
  localparam int QD  = 16;
  localparam int QAW = $clog2(QD);
  localparam int RW  = 16;

  typedef logic [QAW-1:0] qptr_t;

  typedef struct packed {
    logic  start;
    logic  rx_en;
    logic  tx_en;
    logic  loop;
    logic  bot_ie;
    logic  top_ie;
    logic  rxq_en;
    logic  txq_en;
    qptr_t ptr;
    qptr_t last;
  } ctrl_t;

  function automatic qptr_t ptr_inc(qptr_t p);
    return p + qptr_t'(1);
  endfunction

  function automatic logic half_of(qptr_t p);
    return p[QAW-1];
  endfunction

  function automatic logic half_end(qptr_t p);
    return &p[QAW-2:0];
  endfunction
endpackage

// File: rtl/qsfb_tx_shift.sv
module qsfb_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          ready,
  output logic          line
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;

  assign ready = en && (cnt == '0);
  assign line  = (cnt != '0) ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (load && cnt == '0) begin
      sh  <= {1'b1, data, 1'b0};
      cnt <= CW'(FW);
    end else if (cnt != '0) begin
      sh  <= {1'b1, sh[FW-1:1]};
      cnt <= cnt - CW'(1);
    end
  end

  AST_TX_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0)); // R2
endmodule

// File: rtl/qsfb_rx_shift.sv
module qsfb_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line,
  output logic          valid,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DW + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (cnt == '0) begin
        if (!line) cnt <= CW'(1);
      end else if (cnt == CW'(DW + 1)) begin
        valid <= line;
        cnt   <= '0;
      end else begin
        data <= {line, data[DW-1:1]};
        cnt  <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/qsfb_rx_queue.sv
module qsfb_rx_queue
  import qsfb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  qptr_t         rd_idx,
  input  logic          clr_top,
  input  logic          clr_bot,
  output logic [DW-1:0] rd_data,
  output logic          full_top,
  output logic          full_bot,
  output logic          drop
);
  logic [DW-1:0] mem [QD];
  qptr_t wptr;
  logic  tgt_half, tgt_full, accept, fill_top, fill_bot;

  assign tgt_half = half_of(wptr);
  assign tgt_full = tgt_half ? full_bot : full_top;
  assign drop     = wr_en && tgt_full;
  assign accept   = wr_en && !tgt_full;
  assign fill_top = accept && !tgt_half && half_end(wptr);
  assign fill_bot = accept &&  tgt_half && half_end(wptr);
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      full_top <= 1'b0;
      full_bot <= 1'b0;
    end else begin
      if (accept) wptr <= ptr_inc(wptr);
      full_top <= (full_top && !clr_top) || fill_top;
      full_bot <= (full_bot && !clr_bot) || fill_bot;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wptr == qptr_t'(QD - 1)) |=> (wptr == '0)); // R6
  AST_DROP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(wptr)); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_top && !clr_top) |=> full_top); // R7
endmodule

// File: rtl/qsfb_ctrl.sv
module qsfb_ctrl
  import qsfb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [5:0]    bus_addr,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq
);
  localparam logic [5:0] A_CTRL = 6'd0;
  localparam logic [5:0] A_STAT = 6'd1;
  localparam logic [5:0] A_DATA = 6'd2;
  localparam logic [1:0] W_TXQ  = 2'b01;
  localparam logic [1:0] W_RXQ  = 2'b10;

  ctrl_t wv;
  logic  rx_en, tx_en, loop, bot_ie, top_ie, rxq_en, txq_en;
  qptr_t tx_ptr, tx_last;
  logic  tx_active, tx_done, overrun, rx_ready, tx_full;
  logic [DW-1:0] tx_dr, rx_dr;
  logic [3:0]    armed;
  logic [DW-1:0] txq [QD];

  // named internal events
  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, wr_txq, start;
  logic tx_ready, q_load, d_load, q_last, loop_eff, tx_line, rx_line;
  logic rx_valid, q_drop, full_top, full_bot, dr_over;
  logic [DW-1:0] rx_byte, txq_rd, rxq_rd, shift_in;
  logic [3:0]    clr;

  assign wv      = ctrl_t'(bus_wdata);
  assign wr_ctrl = bus_sel && bus_we && bus_addr == A_CTRL;
  assign wr_stat = bus_sel && bus_we && bus_addr == A_STAT;
  assign wr_data = bus_sel && bus_we && bus_addr == A_DATA;
  assign rd_stat = bus_sel && !bus_we && bus_addr == A_STAT;
  assign rd_data = bus_sel && !bus_we && bus_addr == A_DATA;
  assign wr_txq  = bus_sel && bus_we && bus_addr[5:4] == W_TXQ;
  assign start   = wr_ctrl && wv.start;
  assign clr     = {4{wr_stat}} & ~bus_wdata[3:0] & armed;

  assign txq_rd   = txq[tx_ptr];
  assign q_load   = txq_en && tx_active && tx_ready;
  assign d_load   = !txq_en && tx_full && tx_ready;
  assign q_last   = tx_ptr == tx_last;
  assign shift_in = txq_en ? txq_rd : tx_dr;
  assign loop_eff = loop && tx_en && rx_en;
  assign txd      = loop_eff ? 1'b1 : tx_line;
  assign rx_line  = loop_eff ? tx_line : rxd;
  assign dr_over  = rx_valid && !rxq_en && rx_ready && !rd_data;
  assign irq      = (full_top && top_ie) || (full_bot && bot_ie);

  qsfb_tx_shift #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .load(q_load || d_load),
    .data(shift_in), .ready(tx_ready), .line(tx_line));

  qsfb_rx_shift #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .line(rx_line),
    .valid(rx_valid), .data(rx_byte));

  qsfb_rx_queue u_rxq (
    .clk(clk), .rst_n(rst_n), .wr_en(rx_valid && rxq_en), .wr_data(rx_byte),
    .rd_idx(bus_addr[QAW-1:0]), .clr_top(clr[0]), .clr_bot(clr[1]),
    .rd_data(rxq_rd), .full_top(full_top), .full_bot(full_bot), .drop(q_drop));

  always_ff @(posedge clk) begin
    if (wr_txq) txq[bus_addr[QAW-1:0]] <= bus_wdata[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rx_en, tx_en, loop, bot_ie, top_ie, rxq_en, txq_en} <= '0;
      tx_last <= '0;
    end else if (wr_ctrl) begin
      {rx_en, tx_en, loop, bot_ie, top_ie, rxq_en, txq_en} <=
        {wv.rx_en, wv.tx_en, wv.loop, wv.bot_ie, wv.top_ie, wv.rxq_en, wv.txq_en};
      tx_last <= wv.last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ptr    <= '0;
      tx_active <= 1'b0;
    end else begin
      if (wr_ctrl && test_mode)  tx_ptr <= wv.ptr;
      else if (start)            tx_ptr <= '0;
      else if (q_load && !q_last) tx_ptr <= ptr_inc(tx_ptr);
      if (start)                 tx_active <= 1'b1;
      else if (q_load && q_last) tx_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done  <= 1'b0;
      overrun  <= 1'b0;
      rx_ready <= 1'b0;
      tx_full  <= 1'b0;
      tx_dr    <= '0;
      rx_dr    <= '0;
      armed    <= '0;
    end else begin
      if (q_load && q_last) tx_done <= 1'b1;
      else if (start || clr[3]) tx_done <= 1'b0;
      overrun <= (overrun && !clr[2]) || q_drop || dr_over;
      if (wr_data) begin
        tx_dr   <= bus_wdata[DW-1:0];
        tx_full <= 1'b1;
      end else if (d_load) begin
        tx_full <= 1'b0;
      end
      if (rx_valid && !rxq_en) begin
        rx_dr    <= rx_byte;
        rx_ready <= 1'b1;
      end else if (rd_data) begin
        rx_ready <= 1'b0;
      end
      if (wr_stat)      armed <= '0;
      else if (rd_stat) armed <= {tx_done, overrun, full_bot, full_top};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)
      bus_rdata = {1'b0, rx_en, tx_en, loop, bot_ie, top_ie, rxq_en, txq_en, tx_ptr, tx_last};
    else if (bus_addr == A_STAT)
      bus_rdata = {10'b0, !tx_full, rx_ready, tx_done, overrun, full_bot, full_top};
    else if (bus_addr == A_DATA)
      bus_rdata = {{(RW-DW){1'b0}}, rx_dr};
    else if (bus_addr[5:4] == W_RXQ)
      bus_rdata = {{(RW-DW){1'b0}}, rxq_rd};
  end

  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !start && !q_load) |=> $stable(tx_ptr)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_active); // R5
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_load && q_last && !start) |=> !tx_active); // R5
endmodule

// File: tb/qsfb_ctrl_bench.sv
module qsfb_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, test_mode = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, rxd = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic txd, irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // behavioural model of the receive ring
  logic [7:0] m_q [16];
  int m_wp = 0;
  bit m_full [2];
  bit m_ovr = 1'b0;

  qsfb_ctrl u_qsfb_ctrl (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk) rxd = 1'b0;
    for (int i = 0; i < 8; i++) @(negedge clk) rxd = b[i];
    @(negedge clk) rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_rx(input logic [7:0] b);
    int h;
    h = m_wp / 8;
    if (m_full[h]) m_ovr = 1'b1;
    else begin
      m_q[m_wp] = b;
      if (m_wp % 8 == 7) m_full[h] = 1'b1;
      m_wp = (m_wp + 1) % 16;
    end
  endtask

  task automatic cap_tx(output logic [7:0] b, output bit ok);
    bit found = 1'b0;
    b = '0;
    for (int n = 0; n < 200 && !found; n++) begin
      @(negedge clk);
      if (txd == 1'b0) found = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      b[i] = txd;
    end
    @(negedge clk);
    ok = found && (txd == 1'b1);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0] b;
    bit ok;
    bit quiet;
    for (int i = 0; i < 16; i++) m_q[i] = '0;
    m_full[0] = 1'b0; m_full[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(6'd0, r); chk(r == 16'h0000, "R1 ctrl", r, 16'h0000);
    bus_rd(6'd1, r); chk(r == 16'h0020, "R1 status", r, 16'h0020);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R2 unqueued transmit
    bus_wr(6'd0, 16'h2000);
    bus_wr(6'd2, 16'h003C);
    cap_tx(b, ok);
    chk(ok && b == 8'h3C, "R2 frame", b, 8'h3C);
    repeat (2) @(negedge clk);
    bus_rd(6'd1, r); chk(r[5] == 1'b1, "R2 dr free", r[5], 1);

    // R3 unqueued receive
    bus_wr(6'd0, 16'h6000);
    send_rx(8'h96);
    bus_rd(6'd1, r); chk(r[4] == 1'b1, "R3 ready set", r[4], 1);
    bus_rd(6'd2, r); chk(r[7:0] == 8'h96, "R3 data", r[7:0], 8'h96);
    bus_rd(6'd1, r); chk(r[4] == 1'b0, "R3 ready cleared", r[4], 0);

    // R5 queued transmit run, entries 0..3
    for (int i = 0; i < 5; i++) bus_wr(6'(16 + i), 16'(8'h41 + i));
    bus_wr(6'd0, 16'hA103);
    for (int i = 0; i < 4; i++) begin
      cap_tx(b, ok);
      chk(ok && b == 8'(8'h41 + i), "R5 run order", b, 8'h41 + i);
    end
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd != 1'b1) quiet = 1'b0;
    end
    chk(quiet, "R5 stops at last", quiet, 1);
    bus_rd(6'd1, r); chk(r[3] == 1'b1, "R5 done flag", r[3], 1);
    bus_rd(6'd0, r); chk(r[7:4] == 4'd3, "R5 ptr at last", r[7:4], 3);

    // R4 pointer writable only in test mode
    bus_wr(6'd0, 16'h2190);
    bus_rd(6'd0, r); chk(r[7:4] == 4'd3, "R4 ptr locked", r[7:4], 3);
    test_mode = 1'b1;
    bus_wr(6'd0, 16'h2190);
    bus_rd(6'd0, r); chk(r[7:4] == 4'd9, "R4 ptr test write", r[7:4], 9);
    bus_wr(6'd30, 16'h00E1);
    bus_wr(6'd31, 16'h00F2);
    bus_wr(6'd0, 16'hA1EF);
    test_mode = 1'b0;
    cap_tx(b, ok); chk(ok && b == 8'hE1, "R4 run from 14", b, 8'hE1);
    cap_tx(b, ok); chk(ok && b == 8'hF2, "R4 run to 15", b, 8'hF2);
    repeat (4) @(negedge clk);

    // R9 clear protocol on run complete flag
    bus_wr(6'd1, 16'hFFFF);
    bus_wr(6'd1, 16'h0000);
    bus_rd(6'd1, r); chk(r[3] == 1'b1, "R9 clear without read ignored", r[3], 1);
    bus_wr(6'd1, 16'hFFF7);
    bus_rd(6'd1, r); chk(r[3] == 1'b0, "R9 clear after read", r[3], 0);

    // R6 R7 R8 R10 receive queue
    bus_wr(6'd0, 16'h4600);
    for (int i = 0; i < 7; i++) begin
      send_rx(8'(8'h10 + i)); model_rx(8'(8'h10 + i));
    end
    bus_rd(6'd1, r); chk(r[0] == 1'b0, "R7 top not yet full", r[0], 0);
    chk(irq == 1'b0, "R8 irq low", irq, 0);
    send_rx(8'h17); model_rx(8'h17);
    bus_rd(6'd1, r); chk(r[0] == m_full[0], "R7 top full", r[0], 1);
    chk(irq == 1'b1, "R8 irq top", irq, 1);
    bus_wr(6'd0, 16'h4200);
    @(negedge clk);
    chk(irq == 1'b0, "R8 masked", irq, 0);
    bus_rd(6'd1, r); chk(r[0] == 1'b1, "R8 flag kept", r[0], 1);
    for (int i = 0; i < 8; i++) begin
      send_rx(8'(8'hC0 + i)); model_rx(8'(8'hC0 + i));
    end
    bus_rd(6'd1, r); chk(r[1] == m_full[1], "R7 bottom full", r[1], 1);
    bus_wr(6'd0, 16'h4A00);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq bottom", irq, 1);
    send_rx(8'hEE); model_rx(8'hEE);
    bus_rd(6'd1, r); chk(r[2] == m_ovr, "R10 overrun", r[2], 1);
    for (int i = 0; i < 16; i++) begin
      bus_rd(6'(32 + i), r);
      chk(r[7:0] == m_q[i], "R6 entry", r[7:0], m_q[i]);
    end
    bus_rd(6'd1, r);
    bus_wr(6'd1, 16'hFFFE); m_full[0] = 1'b0;
    bus_rd(6'd1, r);
    chk(r[0] == 1'b0 && r[1] == 1'b1, "R9 top cleared bottom kept", r[1:0], 2);
    send_rx(8'h77); model_rx(8'h77);
    bus_rd(6'd32, r); chk(r[7:0] == m_q[0], "R6 wrap to entry 0", r[7:0], 8'h77);
    bus_rd(6'd40, r); chk(r[7:0] == 8'hC0, "R10 dropped frame not stored", r[7:0], 8'hC0);
    bus_rd(6'd1, r); chk(r[2] == 1'b1, "R10 overrun sticky", r[2], 1);

    // R11 loop mode
    bus_wr(6'd0, 16'h7000);
    bus_wr(6'd2, 16'h00A5);
    quiet = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (txd != 1'b1) quiet = 1'b0;
    end
    chk(quiet, "R11 txd idle", quiet, 1);
    bus_rd(6'd1, r); chk(r[4] == 1'b1, "R11 looped frame ready", r[4], 1);
    bus_rd(6'd2, r); chk(r[7:0] == 8'hA5, "R11 looped data", r[7:0], 8'hA5);

    // R12 loop without receiver has no effect
    bus_wr(6'd0, 16'h3000);
    bus_wr(6'd2, 16'h005A);
    cap_tx(b, ok);
    chk(ok && b == 8'h5A, "R12 frame on txd", b, 8'h5A);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule